// File: doc/BRIEF.md
# 32-Bit Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a 32-bit integer datapath. It takes two operands and a 3-bit operation code. It returns a 32-bit result, plus three flags: result-is-zero, carry out of the top bit, and signed overflow. It performs bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

A control decoder turns the operation code into a small group of strobes. The strobes select one of the following:

- operand B, or its inverse, at the adder input
- the carry into the adder
- the source of the result
- whether the arithmetic flags are reported

The datapath holds a segmented adder, the bitwise logic and the result multiplexer. A branch unit usually reads the zero flag after a subtraction to decide whether two registers are equal.

Top module: `alu32`

## Requirements
- R1: Operation code 000 gives the bitwise AND of the two operands.
- R2: Operation code 001 gives the bitwise OR of the two operands.
- R3: Operation code 010 gives the sum of the operands modulo 2^32.
- R4: Operation code 110 gives A minus B modulo 2^32, computed as A + ~B + 1.
- R5: Operation code 111 gives 1 in bit 0 and zeros in bits 31..1 when A is less than B as two's complement numbers, and all zeros otherwise. The answer is correct even when A - B overflows.
- R6: For codes 000, 001, 010, 110 and 111, the zero flag is high exactly when all 32 result bits are zero.
- R7: The carry flag is the carry out of bit 31 of the adder for codes 010 and 110. For subtraction, this makes it high exactly when A >= B as unsigned numbers. The carry flag is low for every other code.
- R8: The overflow flag is high only for codes 010 and 110. It is high when the two adder inputs (A, and B for an add or ~B for a subtract) have equal sign bits and the sign bit of the result differs from them.
- R9: Codes 011, 100 and 101 give a zero result with the zero, carry and overflow flags all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation select |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | High when the result of a defined operation is zero |
| carryFlag | output | 1 | Adder carry out of bit 31 for add and subtract |
| overflowFlag | output | 1 | Signed overflow for add and subtract |

## Verification
The hardest case to reach is a set-on-less-than where A - B overflows. In that case the sign of the difference gives the wrong answer. Uniform random operands seldom produce it together with the matching opcode.

To reach it, the stimulus mixes uniform operands with operands drawn from edge values: the most negative and most positive numbers, zero, one and all-ones. Directed pairs also cover it, such as the most negative number against one and the most positive number against minus one. The same edge pools drive the carry and overflow checks, including additions and subtractions that wrap exactly to zero.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_AND  = 3'd1,
    RS_OR   = 3'd2,
    RS_SUM  = 3'd3,
    RS_SLT  = 3'd4
  } resSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic    invertB;  // feed ~B and carry-in 1 to the adder
    logic    arithEn;  // report carry and overflow
    logic    valid;    // defined operation, zero flag meaningful
    resSel_e resSel;   // result source
  } aluCtrl_t;

endpackage

// File: rtl/alu32_ctrl.sv
module alu32_ctrl
  import alu32_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{invertB: 1'b0, arithEn: 1'b0, valid: 1'b0, resSel: RS_NONE};
    case (opCode)
      OP_AND: begin
        ctrl.valid  = 1'b1;
        ctrl.resSel = RS_AND;
      end
      OP_OR: begin
        ctrl.valid  = 1'b1;
        ctrl.resSel = RS_OR;
      end
      OP_ADD: begin
        ctrl.valid   = 1'b1;
        ctrl.arithEn = 1'b1;
        ctrl.resSel  = RS_SUM;
      end
      OP_SUB: begin
        ctrl.valid   = 1'b1;
        ctrl.arithEn = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.resSel  = RS_SUM;
      end
      OP_SLT: begin
        ctrl.valid   = 1'b1;
        ctrl.invertB = 1'b1;
        ctrl.resSel  = RS_SLT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu32_adder.sv
module alu32_adder #(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  localparam int NSEG = WIDTH / SEG_W;

  logic [NSEG:0] segCarry;

  assign segCarry[0] = carryIn;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_W:0] segSum;
    assign segSum = {1'b0, addA[s*SEG_W +: SEG_W]}
                  + {1'b0, addB[s*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, segCarry[s]};
    assign sum[s*SEG_W +: SEG_W] = segSum[SEG_W-1:0];
    assign segCarry[s+1]         = segSum[SEG_W];
  end

  assign carryOut = segCarry[NSEG];

endmodule

// File: rtl/alu32_datapath.sv
module alu32_datapath
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             overflowFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic             adderCarry;
  logic             signedOvf;
  logic             lessThan;

  assign bEff = ctrl.invertB ? ~opB : opB;

  alu32_adder #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_adder (
    .addA     (opA),
    .addB     (bEff),
    .carryIn  (ctrl.invertB),
    .sum      (sum),
    .carryOut (adderCarry)
  );

  // Equal effective input signs with a different result sign
  assign signedOvf = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  // True sign of A - B: sign of difference corrected by overflow
  assign lessThan  = sum[MSB] ^ signedOvf;

  always_comb begin
    case (ctrl.resSel)
      RS_AND:  result = opA & opB;
      RS_OR:   result = opA | opB;
      RS_SUM:  result = sum;
      RS_SLT:  result = {{(WIDTH-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign zeroFlag     = ctrl.valid && (result == '0);
  assign carryFlag    = ctrl.arithEn && adderCarry;
  assign overflowFlag = ctrl.arithEn && signedOvf;

endmodule

// File: rtl/alu32.sv
module alu32
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SEG_W = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryFlag,
  output logic             overflowFlag
);

  aluCtrl_t ctrl;

  alu32_ctrl u_ctrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu32_datapath #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_dp (
    .opA          (opA),
    .opB          (opB),
    .ctrl         (ctrl),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .carryFlag    (carryFlag),
    .overflowFlag (overflowFlag)
  );

endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opCode,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             carryFlag,
  input logic             overflowFlag
);

  logic isArith;
  logic isUnused;

  assign isArith  = (opCode == 3'b010) || (opCode == 3'b110);
  assign isUnused = (opCode == 3'b011) || (opCode == 3'b100) || (opCode == 3'b101);

  always_comb begin
    // R9
    a_r9_unused_quiet: assert (!isUnused || (result == '0 && !zeroFlag && !carryFlag && !overflowFlag))
      else $error("unused code not quiet");
    // R8
    a_r8_overflow_arith_only: assert (isArith || !overflowFlag)
      else $error("overflow outside add/sub");
    // R7
    a_r7_carry_arith_only: assert (isArith || !carryFlag)
      else $error("carry outside add/sub");
    // R6
    a_r6_zero_matches: assert (isUnused || (zeroFlag == (result == '0)))
      else $error("zero flag mismatch");
    // R5
    a_r5_slt_shape: assert (opCode != 3'b111 || result[WIDTH-1:1] == '0)
      else $error("slt upper bits set");
    // R7 subtract carry equals unsigned no-borrow
    a_r7_sub_carry: assert (opCode != 3'b110 || carryFlag == (opA >= opB))
      else $error("subtract carry mismatch");
  end

endmodule

bind alu32 alu32_chk #(.WIDTH(WIDTH)) u_chk (
  .opA          (opA),
  .opB          (opB),
  .opCode       (opCode),
  .result       (result),
  .zeroFlag     (zeroFlag),
  .carryFlag    (carryFlag),
  .overflowFlag (overflowFlag)
);

// File: tb/alu32_tb.sv
module alu32_tb;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = 3'b000;
  logic [31:0] result;
  logic        zeroFlag, carryFlag, overflowFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  alu32 u_dut (
    .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .zeroFlag(zeroFlag),
    .carryFlag(carryFlag), .overflowFlag(overflowFlag)
  );

  function automatic logic [34:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input logic [2:0] op);
    logic [32:0] wide;
    logic [31:0] r;
    logic z, c, v;
    r = '0; c = 1'b0; v = 1'b0;
    case (op)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[31:0]; c = wide[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'b110: begin
        wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = wide[31:0]; c = wide[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    z = (op == 3'b011 || op == 3'b100 || op == 3'b101) ? 1'b0 : (r == '0);
    return {r, z, c, v};
  endfunction

  function automatic string reqTag(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic applyCheck(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
    logic [34:0] exp;
    @(posedge clk);
    opA = a; opB = b; opCode = op;
    #1;
    exp = refModel(a, b, op);
    checks++;
    if (result !== exp[34:3]) begin
      errors++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h",
               reqTag(op), op, a, b, result, exp[34:3]);
    end
    checks++;
    if (zeroFlag !== exp[2]) begin
      errors++;
      $display("FAIL R6 zero op=%b a=%h b=%h actual=%b expected=%b", op, a, b, zeroFlag, exp[2]);
    end
    checks++;
    if (carryFlag !== exp[1]) begin
      errors++;
      $display("FAIL R7 carry op=%b a=%h b=%h actual=%b expected=%b", op, a, b, carryFlag, exp[1]);
    end
    checks++;
    if (overflowFlag !== exp[0]) begin
      errors++;
      $display("FAIL R8 overflow op=%b a=%h b=%h actual=%b expected=%b", op, a, b, overflowFlag, exp[0]);
    end
  endtask

  function automatic logic [31:0] edgeVal(input int unsigned k);
    case (k % 8)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [2:0] pickOp(input int unsigned k);
    case (k % 8)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b110;
      4: return 3'b111;
      5: return 3'b111;
      6: return 3'b110;
      default: return 3'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd24681357);
    // Idle state: zero inputs with AND (R1, R6)
    #1;
    checks++;
    if (result !== 32'd0 || zeroFlag !== 1'b1 || carryFlag !== 1'b0 || overflowFlag !== 1'b0) begin
      errors++;
      $display("FAIL R6 idle state actual=%h/%b expected=00000000/1", result, zeroFlag);
    end
    // Directed corners
    applyCheck(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b000);  // R1
    applyCheck(32'hF000_0005, 32'h000F_0A00, 3'b001);  // R2
    applyCheck(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);  // R3, R8 overflow
    applyCheck(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);  // R3, R6 wrap to zero, R7 carry
    applyCheck(32'h8000_0000, 32'h8000_0000, 3'b010);  // R8 negative overflow
    applyCheck(32'h8000_0000, 32'h0000_0001, 3'b110);  // R4, R8
    applyCheck(32'h1234_5678, 32'h1234_5678, 3'b110);  // R4, R6 equal
    applyCheck(32'h0000_0000, 32'h0000_0001, 3'b110);  // R7 borrow
    applyCheck(32'h8000_0000, 32'h0000_0001, 3'b111);  // R5 overflowing compare
    applyCheck(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);  // R5 overflowing compare
    applyCheck(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);  // R5 negative below zero
    applyCheck(32'h0000_0005, 32'h0000_0005, 3'b111);  // R5 equal
    applyCheck(32'hFFFF_FFFF, 32'h0000_0001, 3'b011);  // R9
    applyCheck(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b100);  // R9
    applyCheck(32'h8000_0000, 32'hFFFF_FFFF, 3'b101);  // R9
    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      if (i % 3 == 0) begin
        a = edgeVal($urandom);
        b = edgeVal($urandom);
      end else begin
        a = $urandom;
        b = $urandom;
      end
      applyCheck(a, b, pickOp($urandom));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule